// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single transmit line. A producer hands a byte over with a valid/ready handshake. The byte goes into a one-entry holding slot. The serialiser takes it from that slot on the next strobe from an external baud generator, provided it is allowed to start. Every bit of a frame lasts from one strobe to the next.

The frame shape is chosen at run time:
- the word length (5 to 8 data bits),
- the parity (none, even or odd),
- one or two stop bits,
- the bit order.

The shape is captured when a frame starts, so a change during a frame takes effect only from the next frame. A clear-to-send input can hold back frame starts. A break request keeps the line at the space level instead of starting frames. An invert control swaps the line levels at the pin. The busy output covers the whole span from acceptance to the end of the final stop bit. The ready output doubles as the status that the holding slot is empty.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, tx_out is high (idle level, with cfg_invert low), busy is low and in_ready is high.
- R2: A frame consists of the following bits, in this order:
  - a start bit at level 0,
  - the data bits,
  - the parity bit, if enabled,
  - the stop bits at level 1.

  Each bit starts on a bit_tick cycle and holds until the next bit_tick. A held byte starts on the first bit_tick at which a start is permitted.
- R3: cfg_len selects the word length as 5 + cfg_len bits (0 gives 5, 3 gives 8). Bits of in_data above the word length are not sent.
- R4: With cfg_par_en high, a parity bit follows the data. With cfg_par_odd low, the count of ones over the data and parity bits is even; with cfg_par_odd high, that count is odd. With cfg_par_en low, no parity bit is sent.
- R5: cfg_two_stop low gives one stop bit; cfg_two_stop high gives two.
- R6: cfg_msb_first low sends in_data bit 0 first. cfg_msb_first high sends bit (word length - 1) first.
- R7: With cfg_invert high, tx_out is the complement of the line level given in R2 and R10.
- R8: With cfg_cts_en high and cts low, no frame starts. The held byte waits and busy stays high.
- R9: cts going low during a frame does not shorten or alter that frame.
- R10: While brk_req is high, no new frame starts, and the line outside a frame is at level 0 (space). When brk_req is released, the held byte goes out normally.
- R11: busy rises in the cycle after a byte is accepted. It falls on the bit_tick that ends the final stop bit when no byte is held. in_ready is low while the holding slot is full and returns high once that byte's frame starts.
- R12: A byte held when the final stop bit ends starts its own start bit on that same bit_tick, with no idle bit between the frames.
- R13: The line state changes only in bit_tick cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle bit strobe from the baud generator |
| in_valid | input | 1 | Producer has a byte |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Holding slot empty; byte accepted when in_valid is high |
| cfg_len | input | 2 | Word length minus five |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_msb_first | input | 1 | 1 = most significant bit first |
| cfg_invert | input | 1 | Invert line levels at tx_out |
| cfg_cts_en | input | 1 | Gate frame starts on cts |
| cts | input | 1 | Clear to send, active high |
| brk_req | input | 1 | Hold the line in break instead of starting frames |
| tx_out | output | 1 | Serial output |
| busy | output | 1 | A byte is held or a frame is in progress |

## Verification
A table of frames covers the following cases:
- every word length,
- both bit orders,
- all three parity modes,
- both stop counts,
- both line polarities.

The data patterns are chosen so that a reversed order, a wrong parity sense or a leaked upper bit each changes at least one sampled bit. The bench also checks each bit again one cycle later. This separates bits that move only on a strobe from bits that move between strobes.

Directed cases cover the following:
- a byte blocked by clear-to-send and then released,
- clear-to-send dropping during a frame,
- a byte held back by break,
- two bytes sent back to back.

Together these separate the gating of frame starts from the content of a frame once it has started.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_two_stop,
  input  logic          cfg_msb_first,
  input  logic          cfg_invert,
  input  logic          cfg_cts_en,
  input  logic          cts,
  input  logic          brk_req,
  output logic          tx_out,
  output logic          busy
);
  localparam int CW = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2} st_t;

  st_t           st;
  logic [DW-1:0] hold_q, sh_q, ord, mask;
  logic          hold_full, par_q, pe_q, ts_q, line, start_ok, load;
  logic [CW-1:0] cnt_q, last_q, last_idx;

  assign last_idx = CW'(DW - 4) + CW'(cfg_len);
  assign in_ready = !hold_full;
  assign busy     = hold_full || (st != S_IDLE);
  assign start_ok = hold_full && !brk_req && (!cfg_cts_en || cts);
  assign load     = bit_tick && start_ok &&
                    (st == S_IDLE || (st == S_STOP1 && !ts_q) || st == S_STOP2);

  always_comb begin
    int idx;
    for (int i = 0; i < DW; i++) begin
      mask[i] = (i <= int'(last_idx));
      idx     = int'(last_idx) - i;
      if (cfg_msb_first) ord[i] = (idx >= 0) ? hold_q[idx[CW-1:0]] : 1'b0;
      else               ord[i] = hold_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (in_valid && in_ready) begin
      hold_q    <= in_data;
      hold_full <= 1'b1;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sh_q   <= '0;
      par_q  <= 1'b0;
      pe_q   <= 1'b0;
      ts_q   <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (bit_tick) begin
      case (st)
        S_START: begin
          st    <= S_DATA;
          cnt_q <= '0;
        end
        S_DATA: begin
          sh_q  <= sh_q >> 1;
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == last_q) st <= pe_q ? S_PAR : S_STOP1;
        end
        S_PAR:   st <= S_STOP1;
        S_STOP1: st <= ts_q ? S_STOP2 : S_IDLE;
        S_STOP2: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (load) begin
        st     <= S_START;
        sh_q   <= ord;
        par_q  <= (^(hold_q & mask)) ^ cfg_par_odd;
        pe_q   <= cfg_par_en;
        ts_q   <= cfg_two_stop;
        last_q <= last_idx;
      end
    end
  end

  always_comb begin
    case (st)
      S_START: line = 1'b0;
      S_DATA:  line = sh_q[0];
      S_PAR:   line = par_q;
      S_STOP1,
      S_STOP2: line = 1'b1;
      default: line = !brk_req;
    endcase
  end

  assign tx_out = line ^ cfg_invert;

  // R13
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(st));

  // R8
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cfg_cts_en && !cts) |=> st == S_IDLE);

  // R10
  brk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && brk_req) |=> st == S_IDLE);

  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !in_ready));

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !brk_req) |-> tx_out == !cfg_invert);

  // R2
  start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START) |-> (tx_out == cfg_invert && busy));
endmodule

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0, cfg_msb_first = 0;
  logic       cfg_invert = 0, cfg_cts_en = 0, cts = 1, brk_req = 0;
  logic       in_ready, tx_out, busy;
  int         n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_msb_first(cfg_msb_first),
    .cfg_invert(cfg_invert), .cfg_cts_en(cfg_cts_en), .cts(cts),
    .brk_req(brk_req), .tx_out(tx_out), .busy(busy)
  );

  // {invert, msb_first, two_stop, par_odd, par_en, len[1:0], data[7:0]}
  localparam logic [14:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 8'hA5},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 8'h37},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 8'h5A},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h1D},
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 8'h2C},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd3, 8'h80},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 8'hFF},
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  function automatic int frame_len(input logic [1:0] len, input logic pe, input logic ts);
    return 1 + 5 + int'(len) + int'(pe) + 1 + int'(ts);
  endfunction

  function automatic logic frame_bit(input int k, input logic [7:0] d, input logic [1:0] len,
                                     input logic pe, input logic po, input logic msb);
    int  n = 5 + int'(len);
    logic p = po;
    for (int i = 0; i < n; i++) p ^= d[i];
    if (k == 0) return 1'b0;
    if (k <= n) return msb ? d[n - k] : d[k - 1];
    if (pe && k == n + 1) return p;
    return 1'b1;
  endfunction

  task automatic check_frame(input string tag, input logic [7:0] d, input logic [1:0] len,
                             input logic pe, input logic po, input logic ts,
                             input logic msb, input logic inv, input logic finish);
    int nb = frame_len(len, pe, ts);
    for (int k = 0; k < nb; k++) begin
      logic e;
      do_tick();
      e = frame_bit(k, d, len, pe, po, msb) ^ inv;
      chk({tag, " R2 bit"}, {31'd0, tx_out}, {31'd0, e});
      chk({tag, " R11 busy"}, {31'd0, busy}, 32'd1);
      @(negedge clk);
      chk({tag, " R13 hold"}, {31'd0, tx_out}, {31'd0, e});
    end
    if (finish) begin
      do_tick();
      chk({tag, " R11 busy falls"}, {31'd0, busy}, 32'd0);
      chk({tag, " R7 idle level"}, {31'd0, tx_out}, {31'd0, !inv});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_out", {31'd0, tx_out}, 32'd1);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 in_ready", {31'd0, in_ready}, 32'd1);

    // R3 R4 R5 R6 R7 table
    for (int v = 0; v < 8; v++) begin
      logic [14:0] e = VEC[v];
      {cfg_invert, cfg_msb_first, cfg_two_stop, cfg_par_odd, cfg_par_en, cfg_len} = e[14:8];
      push(e[7:0]);
      chk("R11 busy after accept", {31'd0, busy}, 32'd1);
      chk("R11 ready low", {31'd0, in_ready}, 32'd0);
      check_frame("R3 R4 R5 R6 vec", e[7:0], e[9:8], e[10], e[11], e[12], e[13], e[14], 1'b1);
    end

    cfg_invert = 0; cfg_msb_first = 0; cfg_two_stop = 0; cfg_par_en = 0; cfg_len = 2'd3;

    // R8: blocked by cts
    cfg_cts_en = 1; cts = 0;
    push(8'h96);
    for (int i = 0; i < 3; i++) begin
      do_tick();
      chk("R8 held idle", {31'd0, tx_out}, 32'd1);
      chk("R8 busy", {31'd0, busy}, 32'd1);
    end
    cts = 1;
    check_frame("R8 released", 8'h96, 2'd3, 0, 0, 0, 0, 0, 1'b1);

    // R9: cts drops mid frame
    push(8'h3C);
    do_tick();
    chk("R9 start", {31'd0, tx_out}, 32'd0);
    cts = 0;
    for (int k = 1; k < 10; k++) begin
      do_tick();
      chk("R9 bit", {31'd0, tx_out}, {31'd0, frame_bit(k, 8'h3C, 2'd3, 0, 0, 0)});
    end
    do_tick();
    chk("R9 done", {31'd0, busy}, 32'd0);
    cts = 1; cfg_cts_en = 0;

    // R10: break
    brk_req = 1;
    @(negedge clk);
    chk("R10 break level", {31'd0, tx_out}, 32'd0);
    push(8'h81);
    for (int i = 0; i < 3; i++) begin
      do_tick();
      chk("R10 still break", {31'd0, tx_out}, 32'd0);
      chk("R10 ready low", {31'd0, in_ready}, 32'd0);
    end
    brk_req = 0;
    @(negedge clk);
    chk("R10 release idle", {31'd0, tx_out}, 32'd1);
    check_frame("R10 after break", 8'h81, 2'd3, 0, 0, 0, 0, 0, 1'b1);

    // R12: back to back
    cfg_two_stop = 1;
    push(8'hC3);
    fork
      check_frame("R12 first", 8'hC3, 2'd3, 0, 0, 1, 0, 0, 1'b0);
      push(8'h4E);
    join
    check_frame("R12 second", 8'h4E, 2'd3, 0, 0, 1, 0, 0, 1'b1);

    summary();
    $finish;
  end
endmodule